// File: doc/BRIEF.md
# Parallel DAC Register Interface with Load

This block is the digital front end of a multi-channel digital-to-analog converter driven from a parallel bus. A host presents a channel address, a mode level and a 10-bit word, and commits the access with an active-low write strobe framed by an active-low chip select. With the mode pin low, the word goes to configuration: either the global system settings or the settings of the addressed channel. With the mode pin high, the word is sample data for the addressed channel.

Each channel has two converters: a 10-bit main one and an 8-bit sub one. Which one receives a data write is not carried on the bus. It comes from a target bit stored in that channel's configuration, which stays set until it is rewritten. Data is double-buffered. A write fills an input register. A separate active-low load line moves the input registers into the output registers, which are the only values presented on the outputs. An active-low clear line forces every output register to a code that depends on the selected input coding.

The block samples all bus pins on a free-running clock and uses a synchronous, active-high reset.

Top module: `pdac_reg_if`

## Requirements
- R1: After reset, every main and sub output is 0, the input coding is offset binary, and every channel's data target is the main register.
- R2: A bus access commits only on a clock cycle where `wr_n` is seen rising (low in the previous sample, high now) while `cs_n` is low. Holding `wr_n` low, or a rise of `wr_n` while `cs_n` is high, writes nothing.
- R3: With `mode`=0 and `data[9]`=0, `data[0]` sets the system input coding: 0 selects offset binary and 1 selects twos complement.
- R4: With `mode`=0 and `data[9]`=1, `data[0]` sets the data target of the channel at `addr`: 0 selects main and 1 selects sub. This setting persists until the same channel's configuration is written again.
- R5: With `mode`=1, the word goes to the input register chosen by the addressed channel's target. The main register takes `data[9:0]`; the sub register takes `data[7:0]`. The other register of that channel and all other channels stay unchanged.
- R6: While `ldac_n` is high and `clr_n` is high, the output registers hold, and input writes do not reach the outputs.
- R7: While `ldac_n` is low, each output register takes its input register's value one clock later, and keeps following it.
- R8: When `clr_n` is sampled low, every main and sub output register is set on that edge. With offset binary the values are 0x200 (main) and 0x80 (sub). With twos complement both are 0.
- R9: Clear takes precedence over a low `ldac_n` in the same cycle. A bus write whose commit cycle coincides with a low `clr_n` is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; the access commits on its rise |
| mode | input | 1 | 1 = data write, 0 = configuration write |
| addr | input | CH_AW | Channel address |
| data | input | 10 | Bus word |
| ldac_n | input | 1 | Load, active low, level-sensitive |
| clr_n | input | 1 | Hardware clear, active low |
| main_dac | output | NCH*10 | Main output registers, channel 0 in the low bits |
| sub_dac | output | NCH*8 | Sub output registers, channel 0 in the low bits |

## Verification
The assertions assume that all bus pins are already synchronous to `clk` and hold steady across each sampling edge. They also assume that `ldac_n` and `clr_n` are levels held for whole cycles. The bench drives every pin on the falling clock edge and keeps `cs_n`, `addr`, `mode` and `data` steady for the cycle in which `wr_n` rises. As a result, each rise is seen exactly once and no commit lands on a half-changed bus. Clear and load pulses last exactly one cycle unless a test sets out to hold them.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

    localparam int MAIN_W = 10;
    localparam int SUB_W  = 8;

    typedef enum logic {
        COD_OFFSET = 1'b0,
        COD_TWOS   = 1'b1
    } coding_e;

    typedef enum logic {
        TGT_MAIN = 1'b0,
        TGT_SUB  = 1'b1
    } target_e;

    // Layout of a configuration word on the bus
    typedef struct packed {
        logic              chan_sel;   // 1: channel settings, 0: system settings
        logic [MAIN_W-3:0] spare;
        logic              field;      // coding or target bit
    } cfg_word_t;

    // Decoded bus access
    typedef struct packed {
        logic sys_we;
        logic chan_we;
        logic data_we;
        logic field;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic stb, input logic mode,
                                            input logic [MAIN_W-1:0] word);
        cfg_word_t cw;
        bus_cmd_t  c;
        cw        = cfg_word_t'(word);
        c.sys_we  = stb && !mode && !cw.chan_sel;
        c.chan_we = stb && !mode && cw.chan_sel;
        c.data_we = stb && mode;
        c.field   = cw.field;
        return c;
    endfunction

    function automatic logic [MAIN_W-1:0] clr_main(input coding_e c);
        return (c == COD_OFFSET) ? (MAIN_W'(1) << (MAIN_W-1)) : '0;
    endfunction

    function automatic logic [SUB_W-1:0] clr_sub(input coding_e c);
        return (c == COD_OFFSET) ? (SUB_W'(1) << (SUB_W-1)) : '0;
    endfunction

endpackage

// File: rtl/pdac_strobe.sv
module pdac_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic stb
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b1;
        else     wr_q <= wr_n;
    end

    assign stb = !cs_n && wr_n && !wr_q;

    // R2: a commit needs wr_n to have been low at the previous sample
    assert_stb_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        stb |-> ($past(wr_n) == 1'b0));
endmodule

// File: rtl/pdac_sysctl.sv
module pdac_sysctl
    import pdac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  logic    field,
    output coding_e coding
);
    always_ff @(posedge clk) begin
        if (rst)     coding <= COD_OFFSET;
        else if (we) coding <= coding_e'(field);
    end

    assert_coding_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(coding));
endmodule

// File: rtl/pdac_chan.sv
module pdac_chan
    import pdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              dat_we,
    input  logic [MAIN_W-1:0] data,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  coding_e           coding,
    output logic [MAIN_W-1:0] dac_main,
    output logic [SUB_W-1:0]  dac_sub
);
    target_e           target;
    logic [MAIN_W-1:0] in_main;
    logic [SUB_W-1:0]  in_sub;

    always_ff @(posedge clk) begin
        if (rst)         target <= TGT_MAIN;
        else if (cfg_we) target <= target_e'(data[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_main <= '0;
            in_sub  <= '0;
        end else if (dat_we) begin
            if (target == TGT_SUB) in_sub  <= data[SUB_W-1:0];
            else                   in_main <= data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_main <= '0;
            dac_sub  <= '0;
        end else if (!clr_n) begin
            dac_main <= clr_main(coding);
            dac_sub  <= clr_sub(coding);
        end else if (!ldac_n) begin
            dac_main <= in_main;
            dac_sub  <= in_sub;
        end
    end

    assert_hold_main_R6: assert property (@(posedge clk) disable iff (rst)
        (ldac_n && clr_n) |=> $stable(dac_main));
    assert_hold_sub_R6: assert property (@(posedge clk) disable iff (rst)
        (ldac_n && clr_n) |=> $stable(dac_sub));
    assert_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (!ldac_n && clr_n) |=> (dac_main == $past(in_main)) && (dac_sub == $past(in_sub)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (dac_main == clr_main($past(coding))) && (dac_sub == clr_sub($past(coding))));
    assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        !dat_we |=> $stable(in_main) && $stable(in_sub));
endmodule

// File: rtl/pdac_reg_if.sv
module pdac_reg_if
    import pdac_pkg::*;
#(
    parameter int NCH   = 8,
    localparam int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic                  mode,
    input  logic [CH_AW-1:0]      addr,
    input  logic [MAIN_W-1:0]     data,
    input  logic                  ldac_n,
    input  logic                  clr_n,
    output logic [NCH*MAIN_W-1:0] main_dac,
    output logic [NCH*SUB_W-1:0]  sub_dac
);
    logic     stb;
    logic     stb_ok;
    bus_cmd_t cmd;
    coding_e  coding;

    pdac_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .wr_n (wr_n),
        .stb  (stb)
    );

    // Clear wins over any write committing in the same cycle
    assign stb_ok = stb && clr_n;
    assign cmd    = decode_cmd(stb_ok, mode, data);

    pdac_sysctl u_sys (
        .clk    (clk),
        .rst    (rst),
        .we     (cmd.sys_we),
        .field  (cmd.field),
        .coding (coding)
    );

    logic [NCH-1:0] dat_we_v;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit         = (addr == CH_AW'(ch));
        assign dat_we_v[ch] = cmd.data_we && hit;

        pdac_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cmd.chan_we && hit),
            .dat_we   (dat_we_v[ch]),
            .data     (data),
            .ldac_n   (ldac_n),
            .clr_n    (clr_n),
            .coding   (coding),
            .dac_main (main_dac[ch*MAIN_W +: MAIN_W]),
            .dac_sub  (sub_dac[ch*SUB_W +: SUB_W])
        );
    end

    assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dat_we_v));
    assert_clear_drops_write_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dat_we_v == '0));
    assert_coding_on_cs_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(coding));
endmodule

// File: tb/tb_pdac_reg_if.sv
module tb_pdac_reg_if;
    import pdac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int AW         = $clog2(NCH);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cs_n = 1'b1;
    logic                  wr_n = 1'b1;
    logic                  mode = 1'b0;
    logic [AW-1:0]         addr = '0;
    logic [MAIN_W-1:0]     data = '0;
    logic                  ldac_n = 1'b1;
    logic                  clr_n = 1'b1;
    logic [NCH*MAIN_W-1:0] main_dac;
    logic [NCH*SUB_W-1:0]  sub_dac;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdac_reg_if #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
        .addr(addr), .data(data), .ldac_n(ldac_n), .clr_n(clr_n),
        .main_dac(main_dac), .sub_dac(sub_dac)
    );

    function automatic logic [MAIN_W-1:0] mget(int ch);
        return main_dac[ch*MAIN_W +: MAIN_W];
    endfunction
    function automatic logic [SUB_W-1:0] sget(int ch);
        return sub_dac[ch*SUB_W +: SUB_W];
    endfunction

    task automatic check(string req, logic [MAIN_W-1:0] act, logic [MAIN_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Normal access: strobe low for one cycle, then rise while selected
    task automatic bus_write(logic m, int ch, logic [MAIN_W-1:0] d);
        @(negedge clk);
        cs_n = 1'b0; mode = m; addr = AW'(ch); data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic ldac_pulse();
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clr_pulse();
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int ch = 0; ch < NCH; ch++) begin
            check("R1 main reset", mget(ch), '0);
            check("R1 sub reset", MAIN_W'(sget(ch)), '0);
        end
        bus_write(1'b1, 0, 10'h155);
        ldac_pulse();
        check("R1 default target main", mget(0), 10'h155);
        check("R1 default target sub untouched", MAIN_W'(sget(0)), '0);
        clr_pulse();
        check("R1 default offset main clear", mget(0), 10'h200);
        check("R8 offset sub clear", MAIN_W'(sget(0)), 10'h080);
        check("R8 clear all channels", mget(7), 10'h200);
    endtask

    task automatic t_strobe();
        // rise with chip select high
        @(negedge clk); cs_n = 1'b1; mode = 1'b1; addr = AW'(1); data = 10'h3FF; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        // strobe low with cs low, but cs released before the rise
        @(negedge clk); cs_n = 1'b0; data = 10'h2F0; wr_n = 1'b0;
        @(negedge clk); @(negedge clk); cs_n = 1'b1;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        ldac_pulse();
        check("R2 no commit without cs or rise", mget(1), '0);
        // long low strobe then rise while selected
        @(negedge clk); cs_n = 1'b0; data = 10'h0F0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        ldac_pulse();
        check("R2 commit on rise", mget(1), 10'h0F0);
    endtask

    task automatic t_hold();
        bus_write(1'b1, 2, 10'h123);
        repeat (3) @(negedge clk);
        check("R6 output holds with load high", mget(2), '0);
        ldac_pulse();
        check("R7 load transfers", mget(2), 10'h123);
    endtask

    task automatic t_follow();
        @(negedge clk); ldac_n = 1'b0;
        bus_write(1'b1, 3, 10'h0AB);
        check("R7 one cycle behind input", mget(3), '0);
        @(negedge clk);
        check("R7 follows input", mget(3), 10'h0AB);
        ldac_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_target();
        bus_write(1'b0, 4, 10'h201);        // channel settings, target sub
        bus_write(1'b1, 4, 10'h1C5);
        bus_write(1'b1, 5, 10'h077);
        ldac_pulse();
        check("R4 sub target", MAIN_W'(sget(4)), 10'h0C5);
        check("R5 main untouched", mget(4), '0);
        check("R5 other channel keeps main", mget(5), 10'h077);
        check("R5 other channel sub", MAIN_W'(sget(5)), '0);
        bus_write(1'b0, 4, 10'h200);        // target back to main
        bus_write(1'b1, 4, 10'h301);
        ldac_pulse();
        check("R4 main target again", mget(4), 10'h301);
        check("R5 sub unchanged", MAIN_W'(sget(4)), 10'h0C5);
    endtask

    task automatic t_coding();
        bus_write(1'b0, 0, 10'h001);        // system settings, twos complement
        clr_pulse();
        check("R3 twos main clear", mget(4), '0);
        check("R3 twos sub clear", MAIN_W'(sget(4)), '0);
        check("R8 twos clear ch0", mget(0), '0);
        bus_write(1'b0, 0, 10'h000);
        clr_pulse();
        check("R3 offset main clear", mget(4), 10'h200);
        check("R8 offset sub clear", MAIN_W'(sget(4)), 10'h080);
    endtask

    task automatic t_priority();
        bus_write(1'b1, 6, 10'h2AA);
        ldac_pulse();
        check("R7 load ch6", mget(6), 10'h2AA);
        @(negedge clk);
        cs_n = 1'b0; mode = 1'b1; addr = AW'(6); data = 10'h111; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; clr_n = 1'b0; ldac_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1; ldac_n = 1'b1; cs_n = 1'b1;
        check("R9 clear beats load main", mget(6), 10'h200);
        check("R9 clear beats load sub", MAIN_W'(sget(6)), 10'h080);
        ldac_pulse();
        check("R9 write dropped during clear", mget(6), 10'h2AA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_strobe();
        t_hold();
        t_follow();
        t_target();
        t_coding();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule